// File: doc/BRIEF.md
# Shared Level Interrupt Aggregator

This block merges the level-sensitive interrupt pins of several devices that sit on one bus into a small number of shared interrupt lines. Every device has four pins. Each pin is steered to one shared line by a rotation that depends on the device's slot number. A shared line stays asserted for as long as at least one steered pin is high.

The block does not use a plain OR tree. It keeps one counter per shared line. The counter records how many steered pins are currently high. It moves only when a pin actually changes level, so a pin that is held or rewritten at the same level has no effect. The counters are brought out beside the lines so that the occupancy of each line can be observed. Pin levels are sampled on every rising clock edge. All changes seen in one cycle, from any number of devices, are folded into the counters together. There is a single remapping stage.

Top module: `sli_aggregator`

## Requirements
- R1: Device d (0..NUM_DEV-1) presents its four pins p = 0..3 on `pin_lvl[d*4+p]`, and each pin is a 0/1 level.
- R2: Pin p of device d is steered to shared line (p + d) mod NUM_LINES; with the defaults (8 devices, 4 lines) every device puts exactly one pin on every line.
- R3: A pin sampled high at a rising edge while its remembered level is low raises its line's count by one, and the new count is visible right after that edge.
- R4: A pin sampled low while its remembered level is high lowers its line's count by one at that edge.
- R5: A pin sampled at the same level as its remembered level leaves every count unchanged, no matter how many cycles the level is held.
- R6: `irq_out[l]` is high exactly when the count of line l is nonzero.
- R7: Changes on any number of pins in the same cycle are summed into the counts at that one edge; a rise and a fall that land on the same line in one cycle cancel.
- R8: An active-low reset clears every count and every remembered pin level at once. Pins that are still high when reset is released are counted at the first edge after release.
- R9: A count is CNT_W = ceil(log2(max+1)) bits wide, where max is the most pins that can steer to one line (8 with the defaults, so 4 bits). A count never goes below zero and never goes above max.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_DEV*4 | Pin levels, device d pin p at bit d*4+p |
| irq_out | output | NUM_LINES | Shared interrupt lines |
| line_cnt | output | NUM_LINES*CNT_W | Count of line l at bits [l*CNT_W +: CNT_W] |

## Verification
Two functions can fall in the same cycle:
- **Incrementing and decrementing one line's counter.** A rising pin and a falling pin can land on the same line in one cycle. The bench provokes this directly: pin 0 of device 0 rises while pin 3 of device 1 falls, and both steer to line 0. It then applies a stream of pseudo-random pin vectors in which many pins change at once, in both directions.
- **Reset and edge detection.** Reset can take effect while pins are held high. The bench asserts reset with every pin high, checks that the counts drop to zero, and checks that the held pins are counted at the first edge after release.

Each case is judged against an arithmetic model. That model recounts, for every line, the high pins whose slot-rotated index lands on it.

// File: rtl/sli_pkg.sv
package sli_pkg;

  localparam int PINS_PER_DEV = 4;

  // Slot rotation: which shared line a given device pin drives.
  function automatic int line_of(input int dev, input int pin, input int lines);
    return (pin + dev) % lines;
  endfunction

  // Largest number of device pins that can land on a single line.
  function automatic int max_per_line(input int ndev, input int lines);
    return ndev * ((PINS_PER_DEV + lines - 1) / lines);
  endfunction

endpackage

// File: rtl/sli_pin_tracker.sv
module sli_pin_tracker #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic [NUM_PINS-1:0] pin_rise,
  output logic [NUM_PINS-1:0] pin_fall
);

  logic [NUM_PINS-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= pin_lvl;
  end

  // A level equal to the remembered one produces no event.
  assign pin_rise = pin_lvl & ~held_q;
  assign pin_fall = ~pin_lvl & held_q;

  AST_HELD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (held_q == '0)); // R8

endmodule

// File: rtl/sli_line_counter.sv
module sli_line_counter
  import sli_pkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int NUM_LINES = 4,
  parameter int LINE      = 0,
  parameter int CNT_W     = 4,
  localparam int NUM_PINS = NUM_DEV * PINS_PER_DEV,
  localparam int CNT_MAX  = max_per_line(NUM_DEV, NUM_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_rise,
  input  logic [NUM_PINS-1:0] pin_fall,
  output logic [CNT_W-1:0]    cnt
);

  logic [CNT_W-1:0] inc_sum;
  logic [CNT_W-1:0] dec_sum;
  logic [CNT_W-1:0] cnt_q;

  // Sum the events of every pin that is steered onto this line.
  always_comb begin
    inc_sum = '0;
    dec_sum = '0;
    for (int b = 0; b < NUM_PINS; b++) begin
      if (line_of(b / PINS_PER_DEV, b % PINS_PER_DEV, NUM_LINES) == LINE) begin
        inc_sum = inc_sum + CNT_W'(pin_rise[b]);
        dec_sum = dec_sum + CNT_W'(pin_fall[b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + inc_sum - dec_sum;
  end

  assign cnt = cnt_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (dec_sum == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(CNT_MAX)) |-> (inc_sum == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_sum == '0 && dec_sum == '0) |=> $stable(cnt_q)); // R5
  AST_RISE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_sum != '0 && dec_sum == '0) |=> (cnt_q > $past(cnt_q))); // R3
  AST_FALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sum != '0 && inc_sum == '0) |=> (cnt_q < $past(cnt_q))); // R4
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/sli_aggregator.sv
module sli_aggregator
  import sli_pkg::*;
#(
  parameter int NUM_DEV   = 8,
  parameter int NUM_LINES = 4,
  localparam int NUM_PINS = NUM_DEV * PINS_PER_DEV,
  localparam int CNT_W    = $clog2(max_per_line(NUM_DEV, NUM_LINES) + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_lvl,
  output logic [NUM_LINES-1:0]       irq_out,
  output logic [NUM_LINES*CNT_W-1:0] line_cnt
);

  logic [NUM_PINS-1:0] pin_rise;
  logic [NUM_PINS-1:0] pin_fall;

  sli_pin_tracker #(.NUM_PINS(NUM_PINS)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .pin_rise (pin_rise),
    .pin_fall (pin_fall)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CNT_W-1:0] cnt_w;

    sli_line_counter #(
      .NUM_DEV   (NUM_DEV),
      .NUM_LINES (NUM_LINES),
      .LINE      (g),
      .CNT_W     (CNT_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_rise (pin_rise),
      .pin_fall (pin_fall),
      .cnt      (cnt_w)
    );

    assign irq_out[g]                  = |cnt_w;
    assign line_cnt[g*CNT_W +: CNT_W]  = cnt_w;
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_lvl) == '0 && pin_lvl == '0 && $past(rst_n)) |=> (irq_out == '0)); // R6

endmodule

// File: tb/sli_aggregator_tb.sv
module sli_aggregator_tb;

  localparam int ND   = 8;
  localparam int NL   = 4;
  localparam int NP   = ND * 4;
  localparam int CW   = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP-1:0]  pin_lvl = '0;
  logic [NL-1:0]  irq_out;
  logic [NL*CW-1:0] line_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sli_aggregator #(.NUM_DEV(ND), .NUM_LINES(NL)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .irq_out  (irq_out),
    .line_cnt (line_cnt)
  );

  // Model: count every high pin by the line its slot rotation selects.
  function automatic int expect_cnt(input logic [NP-1:0] v, input int line);
    int n = 0;
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p] && ((d + p) % NL) == line) n++;
    return n;
  endfunction

  task automatic check_lines(input string tag, input logic [NP-1:0] v);
    for (int l = 0; l < NL; l++) begin
      int e = expect_cnt(v, l);
      int a = int'(line_cnt[l*CW +: CW]);
      n_chk++;
      if (a != e) begin
        n_fail++;
        $display("FAIL %s line %0d count actual=%0d expected=%0d", tag, l, a, e);
      end
      n_chk++;
      if (irq_out[l] != (e != 0)) begin
        n_fail++;
        $display("FAIL R6 %s line %0d irq actual=%0b expected=%0b", tag, l, irq_out[l], e != 0);
      end
    end
  endtask

  task automatic apply(input string tag, input logic [NP-1:0] v);
    pin_lvl = v;
    @(posedge clk);
    @(negedge clk);
    check_lines(tag, v);
  endtask

  initial begin
    logic [NP-1:0] acc;
    logic [31:0]   lfsr;
    repeat (3) @(negedge clk);
    check_lines("R8 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R8 after release", '0);

    // R1 R2 R3 R4: one pin at a time locates its line.
    for (int i = 0; i < NP; i++) begin
      apply("R2 R3 single rise", NP'(1) << i);
      apply("R4 single fall", '0);
    end

    // R3 R9: fill every line to its maximum one pin per cycle.
    acc = '0;
    for (int i = 0; i < NP; i++) begin
      acc[i] = 1'b1;
      apply("R3 R9 fill", acc);
    end
    // R5: hold the full vector.
    for (int k = 0; k < 4; k++) apply("R5 hold full", acc);
    // R4 R9: drain down to zero.
    for (int i = NP - 1; i >= 0; i--) begin
      acc[i] = 1'b0;
      apply("R4 R9 drain", acc);
    end
    for (int k = 0; k < 3; k++) apply("R5 hold empty", '0);

    // R7: everything in one cycle, both directions.
    apply("R7 all rise", '1);
    apply("R7 all fall", '0);

    // R7: dev0 pin0 (bit 0) rises while dev1 pin3 (bit 7) falls; both on line 0.
    apply("R7 setup", NP'(1) << 7);
    apply("R7 cancel", NP'(1) << 0);
    apply("R5 after cancel", NP'(1) << 0);
    apply("R7 clear", '0);

    // R7: pseudo-random multi-pin changes.
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply("R7 random", NP'(lfsr));
      if (k % 7 == 0) apply("R5 random hold", NP'(lfsr));
    end

    // R8: reset with pins held high, then recount after release.
    apply("R8 preload", '1);
    rst_n = 1'b0;
    @(negedge clk);
    check_lines("R8 reset with pins high", '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_lines("R8 recount after release", '1);
    apply("R4 R8 release drain", '0);

    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule